// File: doc/BRIEF.md
# MIDI serial interface controller

This block connects a host on an 8-bit memory-mapped bus to a MIDI serial link. It sends and receives 8N1 frames: one start bit, eight data bits with the least significant bit first, and one stop bit. Every bit lasts sixteen pulses of a clock-enable input. When that enable pulses at 500 kHz, the link runs at the MIDI rate of 31250 baud, which is 3125 bytes per second.

The host sees two locations, chosen by a single select input:
- **Data location** (select 0). A read returns the byte last received. A write starts a transmission.
- **Control location** (select 1). A read returns status. A write is a command.

Status bit 0 reads 1 when the transmitter can take a new byte. Status bit 1 reads 1 when a received byte is waiting. Bit 4 flags an overrun and bit 5 flags a framing error. Both error flags are sticky and are cleared only by a command write with bit 4 set. A level interrupt request stays high for as long as a received byte is waiting.

The receiver oversamples the line at sixteen times the bit rate. It confirms a start bit at the middle of that bit before it takes in any data. Receive buffering is a single byte.

Top module: `midi_uart_ctrl`

## Requirements
- R1: After reset, status reads 0x01 (transmitter ready, nothing received, no errors), irq_o is low and tx_o is high.
- R2: A received 8N1 frame (start 0, eight data bits LSB first, stop 1, each bit 16 tick_i pulses long) places its byte at the data location (sel_ctrl_i=0).
- R3: A low pulse on rx_i shorter than half a bit is rejected at the start-bit midpoint check and produces no byte (status bit 1 stays 0).
- R4: Status bit 1 is 1 while a received byte waits, and irq_o is high for exactly that time.
- R5: A read of the data location clears status bit 1 and irq_o on the following cycle.
- R6: A write to the data location while the transmitter is idle sends the byte on tx_o as start 0, eight data bits LSB first and stop 1, each 16 tick_i pulses long. tx_o is high when idle.
- R7: Status bit 0 reads 0 from the cycle after the write until the stop bit has ended, and then reads 1 again.
- R8: A write to the data location while status bit 0 is 0 is ignored: no second frame appears and the current frame is unchanged.
- R9: A frame whose stop bit is sampled low still loads its byte and sets status bits 1 and 5.
- R10: A frame that completes while status bit 1 is 1 sets status bit 4. The waiting byte is kept and the new byte is dropped.
- R11: Status bits 4 and 5 stay set across reads of the data location.
- R12: A write to the control location with data bit 4 set clears status bits 4 and 5. A control write with bit 4 clear leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Oversample enable, 16 pulses per bit |
| sel_ctrl_i | input | 1 | 0 selects the data location, 1 selects status (read) or command (write) |
| rd_i | input | 1 | Read strobe, one cycle |
| wr_i | input | 1 | Write strobe, one cycle |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the selected location, combinational |
| rx_i | input | 1 | Serial MIDI input |
| tx_o | output | 1 | Serial MIDI output |
| irq_o | output | 1 | Interrupt request, high while a received byte waits |

## Verification
A received byte, its status bit 1 and irq_o all appear one cycle after the stop bit is sampled at its midpoint. A read then drops irq_o at the next edge, so the bench checks irq_o a full cycle after every read strobe. The first edge of tx_o follows a data write by one cycle, and later bits change every 64 clocks. The transmit monitor therefore samples at the middle of each 64-clock bit, which leaves a few clocks of margin for the tick phase. Status and error checks are made only after the whole frame, including the idle time after it, has been driven, so every sampling point in the receiver has passed.

// File: rtl/midi_pkg.sv
package midi_pkg;
  localparam int ST_TX_RDY = 0;
  localparam int ST_RX_RDY = 1;
  localparam int ST_OVR    = 4;
  localparam int ST_FRM    = 5;
  localparam int CMD_CLR   = 4;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;
endpackage

// File: rtl/midi_tx.sv
module midi_tx #(
  parameter int OS = 16,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  output logic          busy_o,
  output logic          tx_o
);
  localparam int FB = DW + 2;
  localparam int CW = $clog2(OS);
  localparam int BW = $clog2(FB);
  localparam logic [CW-1:0] CNT_LAST = CW'(OS - 1);
  localparam logic [BW-1:0] BIT_LAST = BW'(FB - 1);

  logic [FB-1:0] sh_q;
  logic [CW-1:0] cnt_q;
  logic [BW-1:0] bit_q;
  logic          busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      cnt_q  <= '0;
      bit_q  <= '0;
      busy_q <= 1'b0;
    end else if (!busy_q && load_i) begin
      sh_q   <= {1'b1, data_i, 1'b0};
      cnt_q  <= '0;
      bit_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q && tick_i) begin
      if (cnt_q == CNT_LAST) begin
        cnt_q <= '0;
        sh_q  <= {1'b1, sh_q[FB-1:1]};
        if (bit_q == BIT_LAST) begin
          bit_q  <= '0;
          busy_q <= 1'b0;
        end else begin
          bit_q <= bit_q + 1'b1;
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign tx_o   = sh_q[0];

  assert_tx_start_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && load_i) |=> (busy_o && !tx_o));
  assert_tx_idle_high_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> tx_o);
  assert_tx_busy_ignore_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && load_i && !tick_i) |=> $stable(sh_q));
endmodule

// File: rtl/midi_rx.sv
module midi_rx
  import midi_pkg::*;
#(
  parameter int OS = 16,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          rx_i,
  output logic          done_o,
  output logic [DW-1:0] data_o,
  output logic          ferr_o
);
  localparam int CW  = $clog2(OS);
  localparam int BNW = $clog2(DW);
  localparam logic [CW-1:0]  CNT_LAST = CW'(OS - 1);
  localparam logic [CW-1:0]  CNT_HALF = CW'(OS / 2 - 1);
  localparam logic [BNW-1:0] BIT_LAST = BNW'(DW - 1);

  logic [1:0]     sync_q;
  logic           rx_s;
  rx_state_e      state_q;
  logic [CW-1:0]  cnt_q;
  logic [BNW-1:0] bit_q;
  logic [DW-1:0]  sh_q;

  assign rx_s = sync_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], rx_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      done_o  <= 1'b0;
      ferr_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (tick_i) begin
        unique case (state_q)
          RX_IDLE: begin
            if (!rx_s) begin
              state_q <= RX_START;
              cnt_q   <= '0;
            end
          end
          RX_START: begin
            if (cnt_q == CNT_HALF) begin
              cnt_q <= '0;
              bit_q <= '0;
              // line must still be low at mid start bit
              state_q <= rx_s ? RX_IDLE : RX_DATA;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          RX_DATA: begin
            if (cnt_q == CNT_LAST) begin
              cnt_q <= '0;
              sh_q  <= {rx_s, sh_q[DW-1:1]};
              if (bit_q == BIT_LAST) state_q <= RX_STOP;
              else                   bit_q   <= bit_q + 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          RX_STOP: begin
            if (cnt_q == CNT_LAST) begin
              cnt_q   <= '0;
              state_q <= RX_IDLE;
              done_o  <= 1'b1;
              ferr_o  <= !rx_s;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end

  assign data_o = sh_q;

  assert_rx_glitch_reject_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RX_START && tick_i && cnt_q == CNT_HALF && rx_s) |=> (state_q == RX_IDLE && !done_o));
  assert_rx_done_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (state_q == RX_IDLE));
endmodule

// File: rtl/midi_uart_ctrl.sv
module midi_uart_ctrl
  import midi_pkg::*;
#(
  parameter int OS = 16,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          sel_ctrl_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          rx_i,
  output logic          tx_o,
  output logic          irq_o
);
  logic          rd_data, wr_data, clr_err;
  logic          tx_busy;
  logic          rx_done, rx_ferr;
  logic [DW-1:0] rx_byte;
  logic [DW-1:0] rx_buf_q;
  logic          rx_full_q, err_ovr_q, err_frm_q;
  logic [DW-1:0] status;

  assign rd_data = rd_i && !sel_ctrl_i;
  assign wr_data = wr_i && !sel_ctrl_i;
  assign clr_err = wr_i && sel_ctrl_i && wdata_i[CMD_CLR];

  midi_tx #(.OS(OS), .DW(DW)) i_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .load_i (wr_data),
    .data_i (wdata_i),
    .busy_o (tx_busy),
    .tx_o   (tx_o)
  );

  midi_rx #(.OS(OS), .DW(DW)) i_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .rx_i   (rx_i),
    .done_o (rx_done),
    .data_o (rx_byte),
    .ferr_o (rx_ferr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_buf_q  <= '0;
      rx_full_q <= 1'b0;
      err_ovr_q <= 1'b0;
      err_frm_q <= 1'b0;
    end else begin
      if (clr_err) begin
        err_ovr_q <= 1'b0;
        err_frm_q <= 1'b0;
      end
      if (rd_data) rx_full_q <= 1'b0;
      // new error wins over a same-cycle clear
      if (rx_done) begin
        if (rx_full_q && !rd_data) begin
          err_ovr_q <= 1'b1;
        end else begin
          rx_buf_q  <= rx_byte;
          rx_full_q <= 1'b1;
          if (rx_ferr) err_frm_q <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    status            = '0;
    status[ST_TX_RDY] = !tx_busy;
    status[ST_RX_RDY] = rx_full_q;
    status[ST_OVR]    = err_ovr_q;
    status[ST_FRM]    = err_frm_q;
  end

  assign rdata_o = sel_ctrl_i ? status : rx_buf_q;
  assign irq_o   = rx_full_q;

  assert_rd_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data && !rx_done) |=> !irq_o);
  assert_ovr_keeps_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done && rx_full_q && !rd_data) |=> (err_ovr_q && rx_buf_q == $past(rx_buf_q)));
  assert_err_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_frm_q && !clr_err) |=> err_frm_q);
  assert_err_clear_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_err && !rx_done) |=> (!err_ovr_q && !err_frm_q));
endmodule

// File: tb/test_midi_uart_ctrl.sv
module test_midi_uart_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int BIT_CLK    = 64;  // 16 ticks, one tick per 4 clocks

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       sel = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       rx = 1'b1;
  logic       tx, irq;

  int errors = 0, checks = 0;
  bit auto_rd = 1'b0;
  bit finished = 1'b0;
  int tx_frames = 0;
  logic [7:0] rx_q[$];
  logic [7:0] tx_q[$];

  midi_uart_ctrl i_midi_uart_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .sel_ctrl_i(sel),
    .rd_i(rd), .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata),
    .rx_i(rx), .tx_o(tx), .irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      tick = (c == 3);
      c = (c + 1) % 4;
    end
  end

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic bus_read(logic s, output logic [7:0] d);
    @(negedge clk);
    sel = s; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic bus_write(logic s, logic [7:0] d);
    @(negedge clk);
    sel = s; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic hold(logic v, int n);
    rx = v;
    repeat (n) @(negedge clk);
  endtask

  // driver: serial frame on rx, expected byte pushed when push set
  task automatic send_rx(logic [7:0] b, bit stop_ok, bit push);
    if (push) rx_q.push_back(b);
    hold(1'b0, BIT_CLK);
    for (int i = 0; i < 8; i++) hold(b[i], BIT_CLK);
    if (stop_ok) hold(1'b1, BIT_CLK);
    else begin
      hold(1'b0, 48);
      hold(1'b1, 16);
    end
    hold(1'b1, BIT_CLK);
  endtask

  task automatic send_tx(logic [7:0] b);
    tx_q.push_back(b);
    bus_write(1'b0, b);
  endtask

  // receive monitor (R2, R4, R5)
  initial begin
    logic [7:0] d;
    forever begin
      @(negedge clk);
      if (auto_rd && irq) begin
        bus_read(1'b0, d);
        if (rx_q.size() == 0) check("R2 unexpected rx byte", d, 8'hxx);
        else check("R2 rx byte", d, rx_q.pop_front());
        check("R5 irq after read", {7'd0, irq}, 8'h00);
      end
    end
  end

  // transmit monitor (R6, R8)
  initial begin
    logic [7:0] b;
    forever begin
      @(negedge tx);
      if (rst_n) begin
        repeat (BIT_CLK/2) @(negedge clk);
        check("R6 start bit", {7'd0, tx}, 8'h00);
        for (int i = 0; i < 8; i++) begin
          repeat (BIT_CLK) @(negedge clk);
          b[i] = tx;
        end
        repeat (BIT_CLK) @(negedge clk);
        check("R6 stop bit", {7'd0, tx}, 8'h01);
        if (tx_q.size() == 0) check("R8 unexpected tx frame", b, 8'hxx);
        else check("R6 tx byte", b, tx_q.pop_front());
        tx_frames++;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int f;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1
    bus_read(1'b1, d);
    check("R1 reset status", d, 8'h01);
    check("R1 reset irq", {7'd0, irq}, 8'h00);
    check("R1 reset tx idle", {7'd0, tx}, 8'h01);

    // R2 R4 R5 via scoreboard
    auto_rd = 1'b1;
    send_rx(8'h55, 1'b1, 1'b1);
    send_rx(8'hA3, 1'b1, 1'b1);
    send_rx(8'h00, 1'b1, 1'b1);
    send_rx(8'hFF, 1'b1, 1'b1);
    send_rx(8'h81, 1'b1, 1'b1);
    repeat (20) @(negedge clk);
    auto_rd = 1'b0;
    check("R2 rx queue drained", 8'(rx_q.size()), 8'h00);

    // R3 short glitch
    hold(1'b0, 16);
    hold(1'b1, 12 * BIT_CLK);
    bus_read(1'b1, d);
    check("R3 glitch status", d, 8'h01);
    check("R3 glitch irq", {7'd0, irq}, 8'h00);

    // R6 R7
    f = tx_frames;
    send_tx(8'h3C);
    bus_read(1'b1, d);
    check("R7 tx busy status", d, 8'h00);
    while (tx_frames == f) @(negedge clk);
    repeat (BIT_CLK) @(negedge clk);
    bus_read(1'b1, d);
    check("R7 tx ready after stop", d, 8'h01);
    send_tx(8'hA5);
    while (tx_frames == f + 1) @(negedge clk);
    repeat (BIT_CLK) @(negedge clk);

    // R8 write during busy
    f = tx_frames;
    send_tx(8'hC6);
    bus_write(1'b0, 8'hFF);
    while (tx_frames == f) @(negedge clk);
    repeat (4 * BIT_CLK) @(negedge clk);
    check("R8 no extra frame", 8'(tx_frames - f), 8'h01);
    check("R8 tx idle", {7'd0, tx}, 8'h01);

    // R9 R4 R11 R12 framing error
    send_rx(8'h5A, 1'b0, 1'b0);
    bus_read(1'b1, d);
    check("R9 frame err status", d, 8'h23);
    check("R4 irq pending", {7'd0, irq}, 8'h01);
    bus_read(1'b0, d);
    check("R9 frame err byte", d, 8'h5A);
    @(negedge clk);
    check("R5 irq cleared", {7'd0, irq}, 8'h00);
    bus_read(1'b1, d);
    check("R11 frame flag kept", d, 8'h21);
    bus_write(1'b1, 8'h10);
    bus_read(1'b1, d);
    check("R12 clear frame flag", d, 8'h01);

    // R10 R11 R12 overrun
    send_rx(8'h11, 1'b1, 1'b0);
    send_rx(8'h22, 1'b1, 1'b0);
    bus_read(1'b1, d);
    check("R10 overrun status", d, 8'h13);
    bus_read(1'b0, d);
    check("R10 older byte kept", d, 8'h11);
    bus_read(1'b1, d);
    check("R11 overrun flag kept", d, 8'h11);
    bus_write(1'b1, 8'hEF);
    bus_read(1'b1, d);
    check("R12 other cmd bits no clear", d, 8'h11);
    bus_write(1'b1, 8'h10);
    bus_read(1'b1, d);
    check("R12 clear overrun", d, 8'h01);

    // R2 after errors cleared
    send_rx(8'h7E, 1'b1, 1'b0);
    bus_read(1'b0, d);
    check("R2 rx after clear", d, 8'h7E);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule